// File: doc/BRIEF.md
# End-of-Interrupt Storm Throttle

This block sits beside an interrupt redirection table and reacts to end-of-interrupt broadcasts. Each broadcast carries a vector, a flag saying whether the acknowledged interrupt was level-type, and a flag saying that directed end-of-interrupt handling is active. The block scans the table one pin per cycle, in ascending pin order. For every level-configured pin whose vector matches, it strobes a request to clear that pin's remote-pending flag. It can also strobe a service request so that a pin that is still asserted is delivered again.

A level line that stays asserted after every acknowledge can hold a processor in a loop of interrupt deliveries. To stop this, each pin has a counter of back-to-back redeliveries. When the counter reaches the storm limit it returns to zero and the pin is not redelivered at once. A one-shot delay timer starts instead. When the timer runs out, the block makes one bulk sweep that requests service for every level pin that is still pending and has its remote-pending flag clear. The redirection table itself and the service logic that acts on the requests are outside this block.

Top module: `eoi_storm_ctl`

## Requirements
- R1: Only pins that are configured level-type (`pin_level` bit = 1) and whose `pin_vector` field (bits `p*VEC_W +: VEC_W`) equals the broadcast vector take part in a broadcast. Edge pins never receive a strobe, even when their vector matches.
- R2: A broadcast with `eoi_level` = 0, or with `directed_eoi` = 1, produces no clear strobe and no service request, and leaves every redelivery counter unchanged.
- R3: Every pin that takes part receives a one-cycle `clr_remote` strobe on its own bit.
- R4: A pin that takes part while it is unmasked (`pin_mask` = 0) and pending (`pin_pending` = 1) receives a `svc_req` strobe in the same cycle as its clear strobe, and its counter increments. A pin that takes part while it is masked or not pending gets no service request, and its counter returns to zero.
- R5: When the increment of R4 would bring a counter to `STORM_LIMIT`, the counter returns to zero, no immediate service request is made, and the delay timer starts. The sweep then occurs exactly `DELAY_CYC` cycles after that pin's clear strobe.
- R6: The sweep is a single cycle that asserts `svc_req` for every pin with `pin_level` = 1, `pin_pending` = 1 and `pin_remote` = 0. Edge pins are skipped.
- R7: A storm deferral that occurs while the timer is already running neither restarts nor extends it, and only one sweep results.
- R8: Reset cancels a running delay timer, so no sweep follows. It also clears every counter and drives `busy`, `clr_remote` and `svc_req` to zero.
- R9: A broadcast accepted at a clock edge is scanned at the next `NPINS` edges, pin 0 first, one pin per edge. `busy` stays high for exactly `NPINS` cycles, a pin's strobes appear in the cycle after its scan edge, and any broadcast presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | Broadcast present; accepted when `busy` is low |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_level | input | 1 | 1 when the acknowledged interrupt was level-type |
| directed_eoi | input | 1 | 1 when directed end-of-interrupt handling is active |
| pin_vector | input | NPINS*VEC_W | Vector of each table entry, pin p at bits p*VEC_W +: VEC_W |
| pin_level | input | NPINS | Entry is level-triggered |
| pin_mask | input | NPINS | Entry is masked |
| pin_pending | input | NPINS | Input line of the pin is asserted |
| pin_remote | input | NPINS | Remote-pending flag of each entry |
| busy | output | 1 | Scan in progress |
| clr_remote | output | NPINS | One-cycle request to clear a pin's remote-pending flag |
| svc_req | output | NPINS | One-cycle request to deliver a pin |

## Verification
The broadcast is tried with the following pattern sets:

- **Shared vector across pin types.** One vector is shared by two level pins and one edge pin. This separates matching by vector alone from matching by vector and trigger type.
- **Masked pin.** A masked pin on that same vector separates the clear-only path from the clear-and-redeliver path.
- **Ignored broadcasts before the limit.** Edge-type broadcasts and directed broadcasts are placed between counted broadcasts. The pin must then reach the storm limit on exactly the expected count, which shows the counters were left unchanged.
- **Two pins at the limit together.** Both reach the limit in one scan. This shows whether the second deferral restarts the timer, because the sweep time is measured from the first pin's clear strobe.
- **Reset during the delay.** A reset inside the delay window, followed by fresh redeliveries, shows whether the timer and the counters were cleared.

// File: rtl/eoi_storm_ctl.sv
module eoi_storm_ctl #(
  parameter int NPINS       = 24,
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DELAY_CYC   = 1250000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic                   eoi_level,
  input  logic                   directed_eoi,
  input  logic [NPINS*VEC_W-1:0] pin_vector,
  input  logic [NPINS-1:0]       pin_level,
  input  logic [NPINS-1:0]       pin_mask,
  input  logic [NPINS-1:0]       pin_pending,
  input  logic [NPINS-1:0]       pin_remote,
  output logic                   busy,
  output logic [NPINS-1:0]       clr_remote,
  output logic [NPINS-1:0]       svc_req
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);
  localparam int TMR_W = $clog2(DELAY_CYC + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPINS - 1);

  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] vec_q;
  logic             act_q;
  logic [CNT_W-1:0] cnt [NPINS];
  logic             tmr_run;
  logic [TMR_W-1:0] tmr_cnt;

  logic [VEC_W-1:0] cur_vec;
  logic             hit, want, storm, fire;
  logic [NPINS-1:0] sel, sweep_set;

  assign cur_vec   = pin_vector[idx*VEC_W +: VEC_W];
  assign sel       = NPINS'(1) << idx;
  assign hit       = busy && act_q && pin_level[idx] && (cur_vec == vec_q);
  assign want      = hit && !pin_mask[idx] && pin_pending[idx];
  assign storm     = want && (cnt[idx] == CNT_W'(STORM_LIMIT - 1));
  assign fire      = tmr_run && (tmr_cnt == '0);
  assign sweep_set = pin_level & pin_pending & ~pin_remote;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      idx        <= '0;
      vec_q      <= '0;
      act_q      <= 1'b0;
      tmr_run    <= 1'b0;
      tmr_cnt    <= '0;
      clr_remote <= '0;
      svc_req    <= '0;
      for (int i = 0; i < NPINS; i++) cnt[i] <= '0;
    end else begin
      clr_remote <= hit ? sel : '0;
      svc_req    <= ((want && !storm) ? sel : '0) | (fire ? sweep_set : '0);

      if (hit) begin
        if (want) cnt[idx] <= storm ? '0 : cnt[idx] + CNT_W'(1);
        else      cnt[idx] <= '0;
      end

      if (fire)         tmr_run <= 1'b0;
      else if (tmr_run) tmr_cnt <= tmr_cnt - TMR_W'(1);
      else if (storm) begin
        tmr_run <= 1'b1;
        tmr_cnt <= TMR_W'(DELAY_CYC - 1);
      end

      if (!busy) begin
        if (eoi_valid) begin
          busy  <= 1'b1;
          idx   <= '0;
          vec_q <= eoi_vector;
          act_q <= eoi_level && !directed_eoi;
        end
      end else if (idx == LAST) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/eoi_storm_ctl_chk.sv
module eoi_storm_ctl_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [NPINS-1:0] clr_remote,
  input logic [NPINS-1:0] svc_req,
  input logic [NPINS-1:0] pin_level,
  input logic [NPINS-1:0] pin_pending
);
  localparam int BL_W = $clog2(NPINS + 2) + 1;
  logic [BL_W-1:0] blen;

  always_ff @(posedge clk) begin
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + BL_W'(1);
    else           blen <= '0;
  end

  AST_CLR_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_remote)); // R9
  AST_CLR_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_remote) |-> $past(busy)); // R3
  AST_CLR_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_remote & ~pin_level) == '0); // R1
  AST_SVC_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req & ~pin_level) == '0); // R6
  AST_SVC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req) |-> ((svc_req & ~$past(pin_pending)) == '0)); // R4
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    blen <= BL_W'(NPINS)); // R9
endmodule

bind eoi_storm_ctl eoi_storm_ctl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .clr_remote(clr_remote),
  .svc_req(svc_req), .pin_level(pin_level), .pin_pending(pin_pending)
);

// File: tb/sim_eoi_storm_ctl.sv
`timescale 1ns/1ps
module sim_eoi_storm_ctl;
  localparam int NPINS = 4;
  localparam int VEC_W = 8;
  localparam int LIMIT = 3;
  localparam int DELAY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoi_valid = 1'b0;
  logic [VEC_W-1:0] eoi_vector = '0;
  logic eoi_level = 1'b0;
  logic directed_eoi = 1'b0;
  logic [NPINS*VEC_W-1:0] pin_vector;
  logic [NPINS-1:0] pin_level, pin_mask, pin_pending, pin_remote;
  logic busy;
  logic [NPINS-1:0] clr_remote, svc_req;

  always #4 clk = ~clk;

  eoi_storm_ctl #(.NPINS(NPINS), .VEC_W(VEC_W), .STORM_LIMIT(LIMIT), .DELAY_CYC(DELAY)) u0 (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .directed_eoi(directed_eoi), .pin_vector(pin_vector),
    .pin_level(pin_level), .pin_mask(pin_mask), .pin_pending(pin_pending),
    .pin_remote(pin_remote), .busy(busy), .clr_remote(clr_remote), .svc_req(svc_req));

  typedef struct packed {
    logic       svc;
    logic [1:0] mark;
    logic [7:0] pin;
    logic [7:0] req;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0, cyc = 0;
  int mark_cyc = 0, sweep_cyc = 0;
  int cnt_m[NPINS];
  bit tmr_m = 0, deferred = 0, done = 0;

  task automatic push(bit svc, int pin, int mark, int req);
    item_t it;
    it.svc = svc; it.mark = 2'(mark); it.pin = 8'(pin); it.req = 8'(req);
    exp_q.push_back(it);
  endtask

  task automatic cmp(bit svc, int pin);
    item_t it;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event: actual %s pin %0d, expected none",
               svc ? "svc" : "clr", pin);
    end else begin
      it = exp_q.pop_front();
      if (it.svc != svc || it.pin != 8'(pin)) begin
        errors++;
        $display("FAIL R%0d: actual %s pin %0d, expected %s pin %0d", it.req,
                 svc ? "svc" : "clr", pin, it.svc ? "svc" : "clr", it.pin);
      end
      if (it.mark == 2'd1) mark_cyc = cyc;
      if (it.mark == 2'd2) sweep_cyc = cyc;
    end
  endtask

  // monitor: pops in pin order, clear before service
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int p = 0; p < NPINS; p++) begin
        if (clr_remote[p]) cmp(1'b0, p);
        if (svc_req[p])    cmp(1'b1, p);
      end
    end
  end

  task automatic predict(logic [VEC_W-1:0] vec, bit lvl, bit dir, int req);
    for (int p = 0; p < NPINS; p++) begin
      if (lvl && !dir && pin_level[p] && pin_vector[p*VEC_W +: VEC_W] == vec) begin
        if (!pin_mask[p] && pin_pending[p]) begin
          cnt_m[p]++;
          if (cnt_m[p] == LIMIT) begin
            cnt_m[p] = 0;
            if (!tmr_m) begin
              tmr_m = 1; deferred = 1;
              push(0, p, 1, 5);
            end else push(0, p, 0, 7);
          end else begin
            push(0, p, 0, req);
            push(1, p, 0, req);
          end
        end else begin
          cnt_m[p] = 0;
          push(0, p, 0, req);
        end
      end
    end
  endtask

  task automatic do_eoi(logic [VEC_W-1:0] vec, bit lvl, bit dir, int req);
    @(negedge clk);
    eoi_valid = 1; eoi_vector = vec; eoi_level = lvl; directed_eoi = dir;
    deferred = 0;
    predict(vec, lvl, dir, req);
    @(negedge clk);
    eoi_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic drain_check(int req);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R%0d: actual %0d events missing, expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic wait_sweep();
    bit first = 1;
    for (int p = 0; p < NPINS; p++)
      if (pin_level[p] && pin_pending[p] && !pin_remote[p]) begin
        push(1, p, first ? 2 : 0, 6);
        first = 0;
      end
    repeat (DELAY + 3) @(negedge clk);
    tmr_m = 0;
    checks++;
    if (sweep_cyc - mark_cyc != DELAY) begin
      errors++;
      $display("FAIL R5/R7: actual sweep delay %0d, expected %0d", sweep_cyc - mark_cyc, DELAY);
    end
    drain_check(6);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    tmr_m = 0;
    for (int p = 0; p < NPINS; p++) cnt_m[p] = 0;
    checks++;
    if (busy !== 1'b0 || clr_remote !== '0 || svc_req !== '0) begin
      errors++;
      $display("FAIL R8: actual busy %b clr %b svc %b, expected all zero", busy, clr_remote, svc_req);
    end
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    int n;
    pin_vector  = {8'h30, 8'h30, 8'h41, 8'h30};  // p3 p2 p1 p0
    pin_level   = 4'b0111;                       // p3 is edge
    pin_mask    = 4'b0000;
    pin_pending = 4'b1111;
    pin_remote  = 4'b0000;
    for (int p = 0; p < NPINS; p++) cnt_m[p] = 0;

    do_reset();                         // R8 reset state

    do_eoi(8'h30, 1, 0, 3);             // R1 R3 R4: pins 0,2 only, edge pin 3 skipped
    drain_check(1);

    pin_mask = 4'b0100;                 // R4: masked pin 2 cleared, not serviced
    do_eoi(8'h30, 1, 0, 4);
    drain_check(4);
    pin_mask = 4'b0000;

    do_eoi(8'h30, 0, 0, 2);             // R2: edge-type broadcast ignored
    do_eoi(8'h30, 1, 1, 2);             // R2: directed broadcast ignored
    drain_check(2);
    pin_remote = 4'b0010;
    do_eoi(8'h30, 1, 0, 4);             // R5: pin 0 hits limit only if R2 kept its counter
    checks++;
    if (!deferred) begin errors++; $display("FAIL R5: actual no deferral, expected one"); end
    wait_sweep();                       // R6: sweep pins 0,2; pin 1 remote, pin 3 edge

    do_eoi(8'h30, 1, 0, 4);             // counters nonzero before reset
    do_reset();                         // R8: counters cleared
    do_eoi(8'h30, 1, 0, 8);
    do_eoi(8'h30, 1, 0, 8);
    drain_check(8);
    do_eoi(8'h30, 1, 0, 7);             // R7: pins 0 and 2 both reach limit
    wait_sweep();

    do_eoi(8'h30, 1, 0, 4);
    do_eoi(8'h30, 1, 0, 4);
    do_eoi(8'h30, 1, 0, 8);             // defers pin 0
    do_reset();                         // R8: pending sweep cancelled
    repeat (DELAY + 5) @(negedge clk);
    drain_check(8);

    // R9: broadcast during busy ignored, busy lasts NPINS cycles
    @(negedge clk);
    eoi_valid = 1; eoi_vector = 8'h30; eoi_level = 1; directed_eoi = 0;
    predict(8'h30, 1, 0, 9);
    @(negedge clk);
    checks++;
    if (busy !== 1'b1) begin errors++; $display("FAIL R9: actual busy %b, expected 1", busy); end
    eoi_vector = 8'h41;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
      eoi_valid = 0;
    end
    checks++;
    if (n != NPINS) begin errors++; $display("FAIL R9: actual busy cycles %0d, expected %0d", n, NPINS); end
    repeat (3) @(negedge clk);
    drain_check(9);

    finish_run();
  end
endmodule